// File: doc/BRIEF.md
# Quasi-Resonant Gate Timing Controller

This block is the digital sequencer of a quasi-resonant flyback converter. It decides on which clock the power switch gate goes high and on which clock it drops again. Its inputs are comparator results that have already been digitized and synchronized, plus two counts from outside counters: the number of zero crossings seen since turn-off, and the valley number at which the next turn-on is wanted.

After the gate falls, a ringing-suppression window keeps it low. The window is longer when the zero-crossing level sits below the ringing threshold and shorter when it sits above. Once the window ends, the gate turns on as soon as the zero-crossing count reaches the target. A maximum off time forces a turn-on when the ringing dies out too early. While the gate is on, a blanking window hides the PWM and current-limit comparators, and a maximum on time ends overly long pulses.

A separate short-winding detector must stay asserted for a qualification time. When it does, it latches a fault that keeps the gate low until reset. Each gate turn-off also sends a one-cycle clear pulse to the outside zero-crossing counter.

Top module: `qr_gate_ctrl`

## Requirements
- R1: With `zcAbove`=0 held, after every gate fall the gate stays low for at least SUP_LONG clock cycles, even if the valley condition is already true.
- R2: With `zcAbove`=1 held, the suppression window is SUP_SHORT cycles, so a gate whose valley condition is already met is low for exactly SUP_SHORT cycles.
- R3: After suppression, the gate rises on the clock that follows the first cycle in which `zcCount` >= `valleyTarget` (unsigned compare). A count one below the target does not turn it on.
- R4: If the valley condition never holds, the gate is low for exactly OFF_MAX cycles and then rises.
- R5: `pwmTrip` or `curLimTrip` seen during the first LEB high cycles (high-cycle index 0 to LEB-1) has no effect on the gate.
- R6: `pwmTrip` seen high at high-cycle index c, with LEB <= c < ON_MAX, makes the gate high for exactly c+1 cycles.
- R7: `curLimTrip` ends the high phase with the same timing as R6.
- R8: With no trip input, a high phase lasts exactly ON_MAX cycles.
- R9: `shortTrip` sampled high on SPIKE consecutive clock edges sets `faultOut` and forces `gateOut` low at that edge. A run of SPIKE-1 edges sets nothing.
- R10: Once set, `faultOut` stays high and `gateOut` stays low until reset, whatever the inputs do.
- R11: `zcClr` is high for exactly one cycle: the first low cycle after every gate fall.
- R12: During and after the async active-low reset, `gateOut`, `faultOut` and `zcClr` are 0. The first turn-on then follows the off-time rules, counted from the first clock edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| zcAbove | input | 1 | 1 when zero-crossing voltage is above the ringing threshold |
| pwmTrip | input | 1 | PWM comparator: sensed current above regulation level |
| curLimTrip | input | 1 | Cycle-by-cycle current-limit comparator |
| shortTrip | input | 1 | Short-winding overcurrent comparator |
| zcCount | input | CW | Zero crossings counted since the last turn-off |
| valleyTarget | input | CW | Valley number wanted for turn-on |
| gateOut | output | 1 | Registered gate drive |
| faultOut | output | 1 | Latched short-winding fault |
| zcClr | output | 1 | One-cycle clear pulse for the outside zero-crossing counter |

## Verification
Every decision is registered once. An input sampled at clock edge n shows on `gateOut`, `faultOut` or `zcClr` right after edge n. So an on or off duration equals the index of the deciding cycle plus one. The bench drives inputs and samples outputs at the falling clock edge, and counts phase lengths in falling edges from the first cycle of each phase. It sweeps valley arrival cycles past OFF_MAX for both ringing levels, and trip positions from index 0 through ON_MAX for both trip inputs. The expected length is worked out arithmetically from those indices. Fault qualification is checked edge by edge, and the first turn-on after reset is counted from the first edge after release.

// File: rtl/qr_pkg.sv
package qr_pkg;

  typedef enum logic [1:0] {
    ST_OFF_SUP  = 2'd0,
    ST_OFF_WAIT = 2'd1,
    ST_ON       = 2'd2
  } qrState_t;

  // strobes from control to the timer datapath
  typedef struct packed {
    logic offRun;
    logic onRun;
  } qrStrobe_t;

  // qualified timer results back to control
  typedef struct packed {
    logic supDone;
    logic offMax;
    logic blankOver;
    logic onMax;
    logic shortQual;
  } qrFlags_t;

endpackage

// File: rtl/qr_timer_path.sv
module qr_timer_path
  import qr_pkg::*;
#(
  parameter int SUP_LONG  = 10,
  parameter int SUP_SHORT = 4,
  parameter int OFF_MAX   = 40,
  parameter int LEB       = 3,
  parameter int ON_MAX    = 24,
  parameter int SPIKE     = 5
) (
  input  logic      clk,
  input  logic      rstN,
  input  qrStrobe_t strobe,
  input  logic      zcAbove,
  input  logic      shortTrip,
  output qrFlags_t  flags
);

  localparam int OW = $clog2(OFF_MAX + 1);
  localparam int NW = $clog2(ON_MAX + 1);
  localparam int SW = $clog2(SPIKE + 1);

  localparam logic [OW-1:0] LONG_M1  = OW'(SUP_LONG - 1);
  localparam logic [OW-1:0] SHORT_M1 = OW'(SUP_SHORT - 1);
  localparam logic [OW-1:0] OFF_M1   = OW'(OFF_MAX - 1);
  localparam logic [NW-1:0] LEB_V    = NW'(LEB);
  localparam logic [NW-1:0] ON_M1    = NW'(ON_MAX - 1);
  localparam logic [SW-1:0] SPIKE_M1 = SW'(SPIKE - 1);

  logic [OW-1:0] offCnt;
  logic [NW-1:0] onCnt;
  logic [SW-1:0] shortRun;
  logic [OW-1:0] supLimit;

  // off-time counter: index of current low cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offCnt <= '0;
    end else if (strobe.offRun && offCnt != OFF_M1) begin
      offCnt <= offCnt + 1'b1;
    end else if (!strobe.offRun) begin
      offCnt <= '0;
    end
  end

  // on-time counter: index of current high cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onCnt <= '0;
    end else if (strobe.onRun && onCnt != ON_M1) begin
      onCnt <= onCnt + 1'b1;
    end else if (!strobe.onRun) begin
      onCnt <= '0;
    end
  end

  // consecutive-sample qualifier for the short-winding comparator
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shortRun <= '0;
    end else if (!shortTrip) begin
      shortRun <= '0;
    end else if (shortRun != SPIKE_M1) begin
      shortRun <= shortRun + 1'b1;
    end
  end

  always_comb begin
    supLimit        = zcAbove ? SHORT_M1 : LONG_M1;
    flags.supDone   = (offCnt >= supLimit);
    flags.offMax    = (offCnt >= OFF_M1);
    flags.blankOver = (onCnt >= LEB_V);
    flags.onMax     = (onCnt >= ON_M1);
    flags.shortQual = shortTrip && (shortRun == SPIKE_M1);
  end

  AST_OFF_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    offCnt <= OFF_M1); // R4
  AST_ON_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    onCnt <= ON_M1); // R8
  AST_SHORT_QUAL_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    !shortTrip |=> !flags.shortQual || (SPIKE == 1)); // R9

endmodule

// File: rtl/qr_seq_ctrl.sv
module qr_seq_ctrl
  import qr_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  qrFlags_t      flags,
  input  logic [CW-1:0] zcCount,
  input  logic [CW-1:0] valleyTarget,
  input  logic          pwmTrip,
  input  logic          curLimTrip,
  output qrStrobe_t     strobe,
  output logic          gateOut,
  output logic          faultOut,
  output logic          zcClr
);

  qrState_t state, nextState;
  logic     valleyOk;
  logic     turnOn;
  logic     turnOff;
  logic     faultNext;

  always_comb begin
    valleyOk  = (zcCount >= valleyTarget);
    turnOn    = valleyOk || flags.offMax;
    turnOff   = (flags.blankOver && (pwmTrip || curLimTrip)) || flags.onMax;
    faultNext = faultOut || flags.shortQual;

    nextState = state;
    if (faultNext) begin
      nextState = ST_OFF_SUP;
    end else begin
      case (state)
        ST_OFF_SUP: begin
          if (flags.supDone) nextState = turnOn ? ST_ON : ST_OFF_WAIT;
        end
        ST_OFF_WAIT: begin
          if (turnOn) nextState = ST_ON;
        end
        ST_ON: begin
          if (turnOff) nextState = ST_OFF_SUP;
        end
        default: nextState = ST_OFF_SUP;
      endcase
    end

    strobe.offRun = (nextState != ST_ON) && (state != ST_ON) && !faultNext;
    strobe.onRun  = (nextState == ST_ON) && (state == ST_ON);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_OFF_SUP;
      gateOut  <= 1'b0;
      faultOut <= 1'b0;
      zcClr    <= 1'b0;
    end else begin
      state    <= nextState;
      gateOut  <= (nextState == ST_ON);
      faultOut <= faultNext;
      zcClr    <= gateOut && (nextState != ST_ON);
    end
  end

  AST_SUPPRESS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OFF_SUP && !flags.supDone) |=> !gateOut); // R1
  AST_BLANK_MIN_ON: assert property (@(posedge clk) disable iff (!rstN)
    (gateOut && !flags.blankOver && !flags.onMax && !flags.shortQual && !faultOut)
      |=> gateOut); // R5
  AST_FAULT_GATE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    faultOut |-> !gateOut); // R10
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    faultOut |=> faultOut); // R10
  AST_CLR_AT_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gateOut) |-> zcClr); // R11
  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    zcClr |=> !zcClr); // R11

endmodule

// File: rtl/qr_gate_ctrl.sv
module qr_gate_ctrl
  import qr_pkg::*;
#(
  parameter int SUP_LONG  = 10,
  parameter int SUP_SHORT = 4,
  parameter int OFF_MAX   = 40,
  parameter int LEB       = 3,
  parameter int ON_MAX    = 24,
  parameter int SPIKE     = 5,
  parameter int CW        = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          zcAbove,
  input  logic          pwmTrip,
  input  logic          curLimTrip,
  input  logic          shortTrip,
  input  logic [CW-1:0] zcCount,
  input  logic [CW-1:0] valleyTarget,
  output logic          gateOut,
  output logic          faultOut,
  output logic          zcClr
);

  qrStrobe_t strobe;
  qrFlags_t  flags;

  qr_timer_path #(
    .SUP_LONG (SUP_LONG),
    .SUP_SHORT(SUP_SHORT),
    .OFF_MAX  (OFF_MAX),
    .LEB      (LEB),
    .ON_MAX   (ON_MAX),
    .SPIKE    (SPIKE)
  ) timer_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .zcAbove  (zcAbove),
    .shortTrip(shortTrip),
    .flags    (flags)
  );

  qr_seq_ctrl #(
    .CW(CW)
  ) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .flags       (flags),
    .zcCount     (zcCount),
    .valleyTarget(valleyTarget),
    .pwmTrip     (pwmTrip),
    .curLimTrip  (curLimTrip),
    .strobe      (strobe),
    .gateOut     (gateOut),
    .faultOut    (faultOut),
    .zcClr       (zcClr)
  );

endmodule

// File: tb/qr_gate_ctrl_tb_top.sv
`timescale 1ns/1ps
module qr_gate_ctrl_tb_top;

  localparam int SUP_LONG  = 10;
  localparam int SUP_SHORT = 4;
  localparam int OFF_MAX   = 40;
  localparam int LEB       = 3;
  localparam int ON_MAX    = 24;
  localparam int SPIKE     = 5;
  localparam int CW        = 4;
  localparam int TGT       = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic zcAbove = 1'b0;
  logic pwmTrip = 1'b0;
  logic curLimTrip = 1'b0;
  logic shortTrip = 1'b0;
  logic [CW-1:0] zcCount = '0;
  logic [CW-1:0] valleyTarget = CW'(TGT);
  logic gateOut, faultOut, zcClr;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  qr_gate_ctrl #(
    .SUP_LONG(SUP_LONG), .SUP_SHORT(SUP_SHORT), .OFF_MAX(OFF_MAX),
    .LEB(LEB), .ON_MAX(ON_MAX), .SPIKE(SPIKE), .CW(CW)
  ) dut_i (
    .clk(clk), .rstN(rstN), .zcAbove(zcAbove), .pwmTrip(pwmTrip),
    .curLimTrip(curLimTrip), .shortTrip(shortTrip), .zcCount(zcCount),
    .valleyTarget(valleyTarget), .gateOut(gateOut), .faultOut(faultOut),
    .zcClr(zcClr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // step falling edges until gateOut equals v (bounded)
  task automatic waitGate(input logic v, input string tag);
    int n = 0;
    @(negedge clk);
    while (gateOut !== v && n < 200) begin
      @(negedge clk);
      n++;
    end
    if (gateOut !== v) chk(1'b0, tag, int'(gateOut), int'(v));
  endtask

  // starts at the falling edge of high index 0, ends at high index 0 of next pulse
  task automatic offTrial(input logic level, input int v);
    int hc = 1;
    int k = 0;
    int supLen = level ? SUP_SHORT : SUP_LONG;
    int expLow;
    string tag;
    zcAbove = level;
    zcCount = '0;
    @(negedge clk);
    while (gateOut === 1'b1 && hc < 200) begin
      hc++;
      @(negedge clk);
    end
    chk(hc == LEB + 1, "R6 pwm held high on-time", hc, LEB + 1);
    chk(zcClr === 1'b1, "R11 clear pulse at fall", int'(zcClr), 1);
    while (gateOut === 1'b0 && k < 200) begin
      zcCount = (k >= v) ? CW'(TGT + (v % 2) * 2) : CW'(TGT - 1);
      @(negedge clk);
      k++;
      if (k == 1) chk(zcClr === 1'b0, "R11 clear pulse single", int'(zcClr), 0);
    end
    expLow = (v + 1 > supLen) ? v + 1 : supLen;
    if (expLow > OFF_MAX) expLow = OFF_MAX;
    if (v + 1 >= OFF_MAX) tag = "R4 max off time";
    else if (v + 1 <= supLen) tag = level ? "R2 short suppression" : "R1 long suppression";
    else tag = "R3 valley turn-on";
    chk(k == expLow, tag, k, expLow);
  endtask

  // starts at high index 0; pulses selected trip at high index c
  task automatic onTrial(input int c, input bit useCur);
    int k = 0;
    int lc = 0;
    int expHigh;
    string tag;
    while (gateOut === 1'b1 && k < 200) begin
      if (useCur) curLimTrip = (k == c);
      else pwmTrip = (k == c);
      @(negedge clk);
      k++;
    end
    pwmTrip = 1'b0;
    curLimTrip = 1'b0;
    expHigh = (c >= LEB && c < ON_MAX) ? c + 1 : ON_MAX;
    if (c < LEB) tag = "R5 trip in blanking ignored";
    else if (c >= ON_MAX - 1) tag = "R8 max on time";
    else tag = useCur ? "R7 current-limit turn-off" : "R6 pwm turn-off";
    chk(k == expHigh, tag, k, expHigh);
    while (gateOut === 1'b0 && lc < 200) begin
      @(negedge clk);
      lc++;
    end
    chk(lc == SUP_SHORT, "R2 short suppression ready valley", lc, SUP_SHORT);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int bad;
    int j;
    repeat (3) @(negedge clk);
    chk(gateOut === 1'b0 && faultOut === 1'b0 && zcClr === 1'b0,
        "R12 reset state", int'({gateOut, faultOut, zcClr}), 0);
    pwmTrip = 1'b1;
    rstN = 1'b1;
    waitGate(1'b1, "R4 first turn-on");

    // valley arrival sweep for both ringing levels
    for (int lv = 0; lv < 2; lv++) begin
      for (int v = 0; v <= OFF_MAX + 1; v++) begin
        offTrial(lv[0], v);
      end
    end

    // trip position sweep for both trip inputs
    pwmTrip = 1'b0;
    zcAbove = 1'b1;
    zcCount = CW'(TGT);
    for (int u = 0; u < 2; u++) begin
      for (int c = 0; c <= ON_MAX; c++) begin
        onTrial(c, u[0]);
      end
    end

    // short-winding glitch one sample too short
    shortTrip = 1'b1;
    repeat (SPIKE - 1) @(negedge clk);
    shortTrip = 1'b0;
    bad = 0;
    repeat (60) begin
      @(negedge clk);
      if (faultOut !== 1'b0) bad++;
    end
    chk(bad == 0, "R9 short run below qualification", bad, 0);
    waitGate(1'b0, "R9 sync low");
    waitGate(1'b1, "R9 sync high");

    // qualified short-winding fault during a high phase
    shortTrip = 1'b1;
    for (j = 1; j <= SPIKE + 1; j++) begin
      @(negedge clk);
      chk(faultOut === (j >= SPIKE), "R9 fault qualification edge", int'(faultOut),
          int'(j >= SPIKE));
      chk(gateOut === (j < SPIKE), "R9 gate forced low by fault", int'(gateOut),
          int'(j < SPIKE));
    end
    shortTrip = 1'b0;
    bad = 0;
    repeat (100) begin
      @(negedge clk);
      if (faultOut !== 1'b1 || gateOut !== 1'b0) bad++;
    end
    chk(bad == 0, "R10 fault latched gate held low", bad, 0);

    // reset clears the fault; first turn-on counted from release
    rstN = 1'b0;
    @(negedge clk);
    chk(gateOut === 1'b0 && faultOut === 1'b0 && zcClr === 1'b0,
        "R12 reset clears outputs", int'({gateOut, faultOut, zcClr}), 0);
    zcAbove = 1'b0;
    zcCount = CW'(TGT);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    j = 0;
    do begin
      @(negedge clk);
      j++;
    end while (gateOut !== 1'b1 && j < 200);
    chk(j == SUP_LONG, "R12 first turn-on after release", j, SUP_LONG);
    chk(faultOut === 1'b0, "R12 fault cleared by reset", int'(faultOut), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule